// File: doc/BRIEF.md
# DMA Transmit Mailbox Handshake Controller

This block sits on the peripheral side of a transmit mailbox and paces a block of byte transfers made by an external DMA controller. A local processor starts a transfer by writing the byte count, less one, into a count register. The block then raises its transmit request. The DMA controller answers by driving the active-low acknowledge line, which also serves as chip select, and it strobes bytes into the mailbox. Each completed mailbox write lowers the count by one. The transfer ends when the count steps from zero to all ones. At that point the request drops, a done flag is set and an interrupt is raised.

Two bus styles are supported: a separate write and read strobe pair, and a direction line with a data strobe. A fly-by option swaps the meaning of read and write at the mailbox, so the opposite command counts as a write. All bus pins are synchronized to the core clock. A write is counted once, when its strobe is released. The DMA controller may pause by releasing acknowledge before the end. The request stays up and the count holds until acknowledge returns. Strobes that arrive while acknowledge is high are not counted.

Top module: `dmatx_mbox`

## Requirements
- R1: After synchronous reset, `tx_req` is 0, `cnt_q` is 0, `sta_rdata` is 4'b0000 and `irq` is 0.
- R2: A write of value V through `cnt_we` while `tx_req` is 0 loads `cnt_q` with V and sets `tx_req` on the next cycle.
- R3: A write through `cnt_we` while `tx_req` is 1 is ignored, and `cnt_q` keeps its value.
- R4: With `bus_rwds`=0 and `flyby`=0, each low pulse of `wr_n` taken while `ack_n` is low lowers `cnt_q` by exactly one, on release of the strobe. A pulse on `rd_n` has no effect.
- R5: With `bus_rwds`=1 and `flyby`=0, each low pulse of `ds_n` taken while `ack_n` is low and `rw_n` is low lowers `cnt_q` by one. With `rw_n` high the pulse has no effect.
- R6: With `flyby`=1 the command sense is inverted. On the strobe bus a `rd_n` pulse counts and a `wr_n` pulse does not. On the R/W bus a `ds_n` pulse counts with `rw_n` high and does not count with `rw_n` low.
- R7: While `ack_n` is high, strobes are not counted, `cnt_q` holds and `tx_req` stays 1. Counting resumes once `ack_n` is low again.
- R8: A counted write taken at `cnt_q`=0 sets `cnt_q` to all ones, clears `tx_req`, sets status bit 0 (transmit done) and raises `irq`. A load of N-1 therefore ends after N writes.
- R9: A one-cycle `sta_rd` pulse clears status bit 0 and `irq`. Status bits 3..1 always read 0.
- R10: Strobes that arrive while `tx_req` is 0 are ignored. `cnt_q` and the status are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rwds | input | 1 | 0: write/read strobe bus, 1: R/W line plus data strobe |
| flyby | input | 1 | Invert the read/write command sense at the mailbox |
| cnt_we | input | 1 | Processor write strobe for the count register |
| cnt_wdata | input | 8 | Byte count minus one |
| sta_rd | input | 1 | Processor read of the status register (clears the done bit) |
| sta_rdata | output | 4 | Status register, bit 0 = transmit done |
| ack_n | input | 1 | DMA acknowledge, active low, mailbox chip select |
| wr_n | input | 1 | Write strobe, active low (strobe bus) |
| rd_n | input | 1 | Read strobe, active low (strobe bus) |
| rw_n | input | 1 | Direction line, low = write (R/W bus) |
| ds_n | input | 1 | Data strobe, active low (R/W bus) |
| tx_req | output | 1 | DMA transmit request |
| cnt_q | output | 8 | Current count register value |
| irq | output | 1 | Interrupt, high while the done bit is set |

## Verification
The hardest condition to reach is a pause: acknowledge is released in the middle of a transfer, and any strobe seen during the gap must be dropped. Acknowledge is asynchronous to the core and passes through the same synchronizers as the strobes. To reach the pause, the bench raises `ack_n`, waits several clock periods so the synchronized copy settles, then pulses a valid write strobe. It checks that the count holds and the request stays up, then lowers acknowledge and shows that the next strobe is counted again. The completion wrap is reached with a small load, so that a few counted strobes step the count through zero.

// File: rtl/dmatx_pkg.sv
package dmatx_pkg;

    localparam int CNT_W   = 8;
    localparam int STA_W   = 4;
    localparam int SYNC_ST = 2;
    localparam int PIN_W   = 5;

    typedef enum logic {
        BUS_STROBE = 1'b0,
        BUS_RWDS   = 1'b1
    } bus_e;

    // synchronized bus pins, all active low except rw (low = write)
    typedef struct packed {
        logic ack_n;
        logic wr_n;
        logic rd_n;
        logic rw_n;
        logic ds_n;
    } bus_pins_t;

    localparam bus_pins_t PINS_IDLE = '{default: 1'b1};

    // strobe that carries a mailbox write for the selected bus style
    function automatic logic strobe_low(bus_e bus, logic fly, bus_pins_t p);
        if (bus == BUS_RWDS) return ~p.ds_n;
        return fly ? ~p.rd_n : ~p.wr_n;
    endfunction

    // direction qualifier: only meaningful on the R/W bus
    function automatic logic dir_is_write(bus_e bus, logic fly, bus_pins_t p);
        if (bus == BUS_STROBE) return 1'b1;
        return fly ? p.rw_n : ~p.rw_n;
    endfunction

endpackage

// File: rtl/dmatx_sync.sv
module dmatx_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0] chain [W];

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) chain[b] <= {STAGES{RST_VAL[b]}};
            else     chain[b] <= {chain[b][STAGES-2:0], d[b]};
        end
        assign q[b] = chain[b][STAGES-1];
    end
endmodule

// File: rtl/dmatx_strobe_dec.sv
module dmatx_strobe_dec
    import dmatx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_e      bus,
    input  logic      fly,
    input  bus_pins_t pins,
    output logic      step
);
    logic stb_now;
    logic access;
    logic access_q;

    always_comb begin
        stb_now = strobe_low(bus, fly, pins);
        access  = ~pins.ack_n & stb_now & dir_is_write(bus, fly, pins);
    end

    always_ff @(posedge clk) begin
        if (rst) access_q <= 1'b0;
        else     access_q <= access;
    end

    // a write counts once, when its qualified strobe is released
    assign step = access_q & ~stb_now;

    a_r4_step_single: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
endmodule

// File: rtl/dmatx_counter.sv
module dmatx_counter
    import dmatx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             done_pulse
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_WRAP = '1;

    logic load;
    logic adv;
    logic last;

    always_comb begin
        load = we & ~busy;
        adv  = step & busy;
        last = adv & (cnt == CNT_ZERO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= CNT_ZERO;
            busy       <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= last;
            if (load) begin
                cnt  <= wdata;
                busy <= 1'b1;
            end else if (adv) begin
                cnt <= cnt - 1'b1;
                if (last) busy <= 1'b0;
            end
        end
    end

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (we && !busy) |=> (busy && cnt == $past(wdata)));
    a_r3_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && we && !step) |=> (cnt == $past(cnt)));
    a_r4_dec_one: assert property (@(posedge clk) disable iff (rst)
        (busy && step && cnt != CNT_ZERO) |=> (busy && cnt == $past(cnt) - 1'b1));
    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        (busy && step && cnt == CNT_ZERO) |=> (!busy && cnt == CNT_WRAP && done_pulse));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !we) |=> (cnt == $past(cnt) && !busy));
endmodule

// File: rtl/dmatx_status.sv
module dmatx_status
    import dmatx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_done,
    input  logic             rd,
    output logic [STA_W-1:0] sta,
    output logic             irq
);
    logic done;

    always_ff @(posedge clk) begin
        if (rst)           done <= 1'b0;
        else if (set_done) done <= 1'b1;
        else if (rd)       done <= 1'b0;
    end

    assign sta = {{(STA_W-1){1'b0}}, done};
    assign irq = done;

    a_r8_done_set: assert property (@(posedge clk) disable iff (rst)
        set_done |=> irq);
    a_r9_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd && !set_done) |=> !irq);
endmodule

// File: rtl/dmatx_mbox.sv
module dmatx_mbox
    import dmatx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rwds,
    input  logic             flyby,
    input  logic             cnt_we,
    input  logic [7:0]       cnt_wdata,
    input  logic             sta_rd,
    output logic [3:0]       sta_rdata,
    input  logic             ack_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rw_n,
    input  logic             ds_n,
    output logic             tx_req,
    output logic [7:0]       cnt_q,
    output logic             irq
);
    bus_pins_t raw_pins;
    bus_pins_t s_pins;
    logic      step;
    logic      done_pulse;
    bus_e      bus_sel;

    assign raw_pins = '{ack_n: ack_n, wr_n: wr_n, rd_n: rd_n, rw_n: rw_n, ds_n: ds_n};
    assign bus_sel  = bus_e'(bus_rwds);

    dmatx_sync #(.W(PIN_W), .STAGES(SYNC_ST), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (s_pins)
    );

    dmatx_strobe_dec u_dec (
        .clk  (clk),
        .rst  (rst),
        .bus  (bus_sel),
        .fly  (flyby),
        .pins (s_pins),
        .step (step)
    );

    dmatx_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .we         (cnt_we),
        .wdata      (cnt_wdata),
        .step       (step),
        .cnt        (cnt_q),
        .busy       (tx_req),
        .done_pulse (done_pulse)
    );

    dmatx_status u_sta (
        .clk      (clk),
        .rst      (rst),
        .set_done (done_pulse),
        .rd       (sta_rd),
        .sta      (sta_rdata),
        .irq      (irq)
    );

    a_r7_pause_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_req && s_pins.ack_n && $past(s_pins.ack_n) && !cnt_we) |=> (tx_req && cnt_q == $past(cnt_q)));
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        sta_rdata[3:1] == 3'b000);
endmodule

// File: tb/test_dmatx_mbox.sv
module test_dmatx_mbox;
    localparam int PERIOD = 10;
    localparam int NVEC   = 12;

    // {bus_rwds, flyby, ack_n, pin[1:0], expect_decrement}
    // pin: 0 wr_n, 1 rd_n, 2 ds_n with rw_n low, 3 ds_n with rw_n high
    localparam logic [5:0] VEC [NVEC] = '{
        6'b0_0_0_00_1, 6'b0_0_0_01_0, 6'b0_0_1_00_0,
        6'b0_1_0_01_1, 6'b0_1_0_00_0, 6'b0_1_1_01_0,
        6'b1_0_0_10_1, 6'b1_0_0_11_0, 6'b1_0_1_10_0,
        6'b1_1_0_11_1, 6'b1_1_0_10_0, 6'b1_1_1_11_0
    };

    logic clk = 0;
    logic rst = 1;
    logic bus_rwds = 0, flyby = 0, cnt_we = 0, sta_rd = 0;
    logic [7:0] cnt_wdata = 0;
    logic ack_n = 1, wr_n = 1, rd_n = 1, rw_n = 1, ds_n = 1;
    logic [3:0] sta_rdata;
    logic tx_req, irq;
    logic [7:0] cnt_q;
    int errors = 0, checks = 0;

    always #(PERIOD/2) clk = ~clk;

    dmatx_mbox i_dmatx_mbox (
        .clk(clk), .rst(rst), .bus_rwds(bus_rwds), .flyby(flyby),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .sta_rd(sta_rd), .sta_rdata(sta_rdata),
        .ack_n(ack_n), .wr_n(wr_n), .rd_n(rd_n), .rw_n(rw_n), .ds_n(ds_n),
        .tx_req(tx_req), .cnt_q(cnt_q), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        cyc(3);
        @(negedge clk); rst = 0;
        cyc(1);
    endtask

    task automatic load(logic [7:0] v);
        @(negedge clk); cnt_wdata = v; cnt_we = 1;
        @(negedge clk); cnt_we = 0;
    endtask

    task automatic pulse(logic ack, logic [1:0] pin);
        @(negedge clk);
        ack_n = ack;
        rw_n  = (pin == 2'd3);
        cyc(3);
        @(negedge clk);
        case (pin)
            2'd0: wr_n = 0;
            2'd1: rd_n = 0;
            default: ds_n = 0;
        endcase
        cyc(4);
        @(negedge clk); wr_n = 1; rd_n = 1; ds_n = 1;
        cyc(5);
        @(negedge clk); ack_n = 1; rw_n = 1;
        cyc(4);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 tx_req", tx_req, 0);
        chk("R1 cnt_q", cnt_q, 0);
        chk("R1 sta", sta_rdata, 0);
        chk("R1 irq", irq, 0);

        // table: R4 R5 R6 R7 decode per bus style
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            bus_rwds = VEC[i][5];
            flyby    = VEC[i][4];
            load(8'd5);
            cyc(1);
            pulse(VEC[i][3], VEC[i][2:1]);
            chk($sformatf("R4/R5/R6/R7 vec%0d cnt", i), cnt_q, 5 - VEC[i][0]);
            chk($sformatf("R7 vec%0d req", i), tx_req, 1);
        end

        // R2 load and R3 ignore while busy
        do_reset(); bus_rwds = 0; flyby = 0;
        @(negedge clk); cnt_wdata = 8'd9; cnt_we = 1;
        @(negedge clk); cnt_we = 0;
        chk("R2 cnt", cnt_q, 9);
        chk("R2 req", tx_req, 1);
        load(8'd3);
        cyc(1);
        chk("R3 cnt", cnt_q, 9);

        // R7 pause then resume
        pulse(1'b1, 2'd0);
        chk("R7 paused cnt", cnt_q, 9);
        chk("R7 paused req", tx_req, 1);
        pulse(1'b0, 2'd0);
        chk("R7 resume cnt", cnt_q, 8);

        // R8 completion: load 2 -> three writes
        do_reset(); bus_rwds = 1; flyby = 0;
        load(8'd2);
        pulse(1'b0, 2'd2);
        pulse(1'b0, 2'd2);
        chk("R8 before last cnt", cnt_q, 0);
        chk("R8 before last irq", irq, 0);
        chk("R8 before last req", tx_req, 1);
        pulse(1'b0, 2'd2);
        chk("R8 wrap cnt", cnt_q, 255);
        chk("R8 req off", tx_req, 0);
        chk("R8 sta", sta_rdata, 1);
        chk("R8 irq", irq, 1);

        // R10 strobes while idle ignored
        pulse(1'b0, 2'd2);
        chk("R10 cnt", cnt_q, 255);
        chk("R10 sta", sta_rdata, 1);

        // R9 status read clears
        @(negedge clk); sta_rd = 1;
        @(negedge clk); sta_rd = 0;
        chk("R9 sta", sta_rdata, 0);
        chk("R9 irq", irq, 0);

        // R10 from reset idle
        do_reset(); bus_rwds = 0; flyby = 0;
        pulse(1'b0, 2'd0);
        chk("R10 reset idle cnt", cnt_q, 0);
        chk("R10 reset idle req", tx_req, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule